// File: doc/BRIEF.md
# Multi-Mode Receive Sample FIFO

This block sits between a serial receiver and a 32-bit internal bus. The receiver pushes one sample per cycle. The bus side pulls samples with a read request that carries a sample count. A 2-bit mode input sets the geometry:

- Modes 00 and 01 store up to 32 byte samples.
- Mode 10 stores up to 16 halfword samples.
- Mode 11 stores up to 16 time slots. Each slot is 21 bits: 20 data bits plus a frame-start marker.

Every read returns its samples packed from bit 31 downward. In time-slot mode, bus bit 11 flags the slot that opens a new frame.

Three command pulses control the receive side: enable, disable and receiver reset. Disabling the receiver stops new samples from entering, but the samples already stored can still be read. A receiver reset empties the store, clears the sticky overrun status and the read word, and leaves the receiver off until it is enabled again. The mode is expected to stay fixed while samples are stored.

All outputs are registered. A push or a read takes effect at the clock edge that samples it, and `rd_data` holds the word from the last read until the next read.

Top module: `slotrx_fifo`

## Requirements
- R1: After the reset input is released, `level` is 0, `empty` is 1, `full` is 0, `overrun` is 0, `rx_on` is 0 and `rd_data` is 0.
- R2: A push is stored only while `rx_on` is 1. `rx_enable` sets `rx_on` and `rx_disable` clears it. When both pulse in the same cycle, the disable wins.
- R3: Capacity is 32 samples in modes 00 and 01, and 16 samples in modes 10 and 11. `full` is 1 exactly when `level` equals the capacity of the current mode.
- R4: A push into a full store is discarded and sets `overrun`, which stays set until a receiver reset. If a read in the same cycle frees room, the push is accepted and `overrun` is not set.
- R5: In modes 00 and 01, `rd_cnt` 00 returns 1 byte, 01 returns 2 bytes, and 10 or 11 returns 4 bytes. Byte k (k = 0 is the oldest) sits on bits 31-8k down to 24-8k, and lanes not returned read as 0.
- R6: In mode 10, `rd_cnt` 00 returns 1 halfword and any other code returns 2. Halfword k sits on bits 31-16k down to 16-16k, and lanes not returned read as 0.
- R7: In mode 11, each read returns exactly one slot whatever `rd_cnt` is. A slot without the first-slot mark returns its 20 data bits on bits 31..12, with bits 11..0 at 0.
- R8: In mode 11, a slot pushed with `push_first` = 1 keeps only `push_data[15:0]`. A read returns those bits on bits 31..16, drives bit 11 to 1, and drives all other bits to 0.
- R9: A read that asks for more samples than are stored returns only those available and zeros the rest. A read of an empty store returns 0 and leaves `level` unchanged.
- R10: Stored samples can be read while `rx_on` is 0.
- R11: `rx_reset` clears the stored samples, `overrun`, `rd_data` and `rx_on`. A push or read in the same cycle is ignored.
- R12: Samples are returned in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Geometry: 00/01 bytes, 10 halfwords, 11 time slots |
| rx_enable | input | 1 | Pulse: turn the receive side on |
| rx_disable | input | 1 | Pulse: turn the receive side off |
| rx_reset | input | 1 | Pulse: clear store, status and read word; turn off |
| push_vld | input | 1 | Sample present from the receiver |
| push_data | input | 20 | Sample, right-aligned |
| push_first | input | 1 | Sample is the first slot of a frame (mode 11) |
| rd_req | input | 1 | Bus read request |
| rd_cnt | input | 2 | Samples requested per read |
| rd_data | output | 32 | Top-aligned word from the last read |
| level | output | 6 | Number of stored samples |
| empty | output | 1 | No sample stored |
| full | output | 1 | Store at the capacity of the current mode |
| overrun | output | 1 | Sticky: a push was lost to a full store |
| rx_on | output | 1 | Receive side accepts pushes |

## Verification
A push and a read can fall in the same clock cycle. This matters most when the store is full, because the read frees the room the push needs.

The bench fills the halfword store to 16 entries, then raises `rd_req` and `push_vld` on the same edge. It expects the head sample on `rd_data`, `level` still at 16, and `overrun` still clear. A lone push that follows must then be rejected and set `overrun`. Draining the store afterwards confirms that the pushed sample landed behind the older ones.

// File: rtl/slotrx_pkg.sv
package slotrx_pkg;
  localparam int SAMPLE_W = 20;
  localparam int BUS_W    = 32;
  localparam int LANES    = 4;

  typedef enum logic [1:0] {
    MODE_UART = 2'b00,
    MODE_BYTE = 2'b01,
    MODE_HALF = 2'b10,
    MODE_SLOT = 2'b11
  } rxmode_e;

  typedef struct packed {
    logic                first;
    logic [SAMPLE_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/slotrx_ctl.sv
module slotrx_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_enable,
  input  logic rx_disable,
  input  logic rx_reset,
  input  logic ovr_set,
  output logic rx_on,
  output logic overrun
);
  logic on_d, on_q;
  logic ovr_d, ovr_q;

  always_comb begin
    on_d = on_q;
    if (rx_reset || rx_disable) on_d = 1'b0;
    else if (rx_enable)         on_d = 1'b1;
  end

  always_comb begin
    ovr_d = ovr_q;
    if (rx_reset)     ovr_d = 1'b0;
    else if (ovr_set) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      on_q  <= on_d;
      ovr_q <= ovr_d;
    end
  end

  assign rx_on   = on_q;
  assign overrun = ovr_q;

  // R2: a disable pulse always leaves the receive side off
  p_disable_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_disable |=> !rx_on);
  // R4: overrun holds until a receiver reset
  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rx_reset) |=> overrun);
endmodule

// File: rtl/slotrx_store.sv
module slotrx_store #(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  slotrx_pkg::entry_t     wr_entry,
  input  logic [2:0]             pop_n,
  output logic [LVL_W-1:0]       level,
  output slotrx_pkg::entry_t     heads [slotrx_pkg::LANES]
);
  import slotrx_pkg::*;

  entry_t           mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             wr_go;

  assign wr_go = wr_en && !clr;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    lvl_d    = lvl_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      lvl_d    = '0;
    end else begin
      if (wr_go) wr_ptr_d = wr_ptr_q + PTR_W'(1);
      rd_ptr_d = rd_ptr_q + PTR_W'(pop_n);
      lvl_d    = lvl_q + LVL_W'(wr_go) - LVL_W'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      lvl_q    <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr_q] <= wr_entry;
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_head
      assign heads[i] = mem[rd_ptr_q + PTR_W'(i)];
    end
  endgenerate

  assign level = lvl_q;

  // R9: never more popped than stored
  p_pop_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    LVL_W'(pop_n) <= lvl_q);
  // R3: the count never exceeds the storage depth
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));
endmodule

// File: rtl/slotrx_align.sv
module slotrx_align (
  input  slotrx_pkg::rxmode_e    mode,
  input  logic [2:0]             take_n,
  input  slotrx_pkg::entry_t     heads [slotrx_pkg::LANES],
  output logic [slotrx_pkg::BUS_W-1:0] word
);
  import slotrx_pkg::*;

  always_comb begin
    word = '0;
    unique case (mode)
      MODE_SLOT: begin
        if (take_n != 3'd0) begin
          if (heads[0].first) begin
            word[31:16] = heads[0].data[15:0];
            word[11]    = 1'b1;
          end else begin
            word[31:12] = heads[0].data;
          end
        end
      end
      MODE_HALF: begin
        for (int k = 0; k < 2; k++)
          if (3'(k) < take_n) word[31-16*k -: 16] = heads[k].data[15:0];
      end
      default: begin
        for (int k = 0; k < LANES; k++)
          if (3'(k) < take_n) word[31-8*k -: 8] = heads[k].data[7:0];
      end
    endcase
  end
endmodule

// File: rtl/slotrx_fifo.sv
module slotrx_fifo #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             rx_enable,
  input  logic             rx_disable,
  input  logic             rx_reset,
  input  logic             push_vld,
  input  logic [19:0]      push_data,
  input  logic             push_first,
  input  logic             rd_req,
  input  logic [1:0]       rd_cnt,
  output logic [31:0]      rd_data,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             overrun,
  output logic             rx_on
);
  import slotrx_pkg::*;

  logic        rs_q1, rs_q2, srst_n;
  rxmode_e     mode_e;
  logic [2:0]  req_n, pop_n;
  logic [LVL_W-1:0] cap, lvl;
  logic        push_try, room, accept, ovr_set;
  entry_t      wr_entry;
  entry_t      heads [LANES];
  logic [31:0] word, rd_d, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign srst_n = rs_q2;

  assign mode_e = rxmode_e'(mode);
  assign cap    = mode[1] ? LVL_W'(DEPTH / 2) : LVL_W'(DEPTH);

  always_comb begin
    unique case (mode_e)
      MODE_SLOT: req_n = 3'd1;
      MODE_HALF: req_n = (rd_cnt == 2'b00) ? 3'd1 : 3'd2;
      default:   req_n = (rd_cnt == 2'b00) ? 3'd1 :
                         (rd_cnt == 2'b01) ? 3'd2 : 3'd4;
    endcase
  end

  always_comb begin
    pop_n = 3'd0;
    if (rd_req && !rx_reset)
      pop_n = (LVL_W'(req_n) > lvl) ? lvl[2:0] : req_n;
  end

  assign push_try = push_vld && rx_on && !rx_reset;
  assign room     = (lvl - LVL_W'(pop_n)) < cap;
  assign accept   = push_try && room;
  assign ovr_set  = push_try && !room;

  always_comb begin
    wr_entry.data  = push_data;
    wr_entry.first = (mode_e == MODE_SLOT) && push_first;
  end

  slotrx_ctl u_ctl (
    .clk(clk), .rst_n(srst_n), .rx_enable(rx_enable), .rx_disable(rx_disable),
    .rx_reset(rx_reset), .ovr_set(ovr_set), .rx_on(rx_on), .overrun(overrun)
  );

  slotrx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(srst_n), .clr(rx_reset), .wr_en(accept),
    .wr_entry(wr_entry), .pop_n(pop_n), .level(lvl), .heads(heads)
  );

  slotrx_align u_align (
    .mode(mode_e), .take_n(pop_n), .heads(heads), .word(word)
  );

  always_comb begin
    rd_d = rd_q;
    if (rx_reset)    rd_d = '0;
    else if (rd_req) rd_d = word;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign level   = lvl;
  assign empty   = (lvl == '0);
  assign full    = (lvl == cap);

  // R11: receiver reset clears everything observable
  p_rst_clear_r11: assert property (@(posedge clk) disable iff (!srst_n)
    rx_reset |=> (level == '0 && !overrun && !rx_on && rd_data == '0));
  // R2: nothing enters while the receive side is off
  p_off_no_growth_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !rx_on |=> level <= $past(level));
  // R9: an empty read yields a zero word
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_req && empty && !rx_reset) |=> rd_data == '0);
  // R7: slot reads never touch the low 11 bits
  p_slot_low_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_req && !rx_reset && mode == 2'b11) |=> rd_data[10:0] == '0);
  // R4: a full store with no read or reset keeps its count
  p_full_hold_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (full && !rd_req && !rx_reset && $stable(mode)) |=> level == $past(level));
endmodule

// File: tb/slotrx_fifo_bench.sv
`timescale 1ns/1ps
module slotrx_fifo_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rx_enable = 0, rx_disable = 0, rx_reset = 0;
  logic push_vld = 0, push_first = 0;
  logic [19:0] push_data = '0;
  logic rd_req = 0;
  logic [1:0] rd_cnt = 2'b00;
  logic [31:0] rd_data;
  logic [5:0] level;
  logic empty, full, overrun, rx_on;

  int total = 0, bad = 0;
  logic [20:0] mq [$];
  logic [31:0] exp_q [$];
  string tag_q [$];
  logic rd_seen = 1'b0;
  bit m_on = 0;

  always #2.5 clk = ~clk;

  slotrx_fifo u_slotrx_fifo (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_enable(rx_enable),
    .rx_disable(rx_disable), .rx_reset(rx_reset), .push_vld(push_vld),
    .push_data(push_data), .push_first(push_first), .rd_req(rd_req),
    .rd_cnt(rd_cnt), .rd_data(rd_data), .level(level), .empty(empty),
    .full(full), .overrun(overrun), .rx_on(rx_on)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read word against the scoreboard
  always @(posedge clk) rd_seen <= rd_req && !rx_reset;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R12 unexpected read", rd_data, 32'hx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  function automatic int mcap();
    return mode[1] ? 16 : 32;
  endfunction

  task automatic build(input logic [1:0] c, output logic [31:0] w);
    int want;
    logic [20:0] e;
    w = '0;
    want = (mode == 2'b11) ? 1 : (mode == 2'b10) ? ((c == 0) ? 1 : 2)
         : ((c == 0) ? 1 : (c == 1) ? 2 : 4);
    for (int k = 0; k < want; k++) begin
      if (mq.size() > 0) begin
        e = mq.pop_front();
        if (mode == 2'b11) begin
          if (e[20]) w = {e[15:0], 4'h0, 1'b1, 11'h0};
          else       w = {e[19:0], 12'h0};
        end else if (mode == 2'b10) w[31-16*k -: 16] = e[15:0];
        else                        w[31-8*k -: 8]  = e[7:0];
      end
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cmd_en();  rx_enable = 1; m_on = 1; cyc(); rx_enable = 0; endtask
  task automatic cmd_dis(); rx_disable = 1; m_on = 0; cyc(); rx_disable = 0; endtask
  task automatic cmd_rst(); rx_reset = 1; push_vld = 1; rd_req = 1; m_on = 0; mq.delete();
    cyc(); rx_reset = 0; push_vld = 0; rd_req = 0; endtask

  task automatic push(input logic [19:0] d, input logic f);
    push_vld = 1; push_data = d; push_first = f;
    if (m_on && mq.size() < mcap()) mq.push_back({(mode == 2'b11) && f, d});
    cyc(); push_vld = 0; push_first = 0;
  endtask

  task automatic rd(input logic [1:0] c, input string tag);
    logic [31:0] w;
    build(c, w);
    exp_q.push_back(w); tag_q.push_back(tag);
    rd_req = 1; rd_cnt = c; cyc(); rd_req = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) cyc();
    rst_n = 1;
    repeat (3) cyc();
    // R1 reset state
    check("R1 level", 32'(level), 0);
    check("R1 flags", {28'h0, empty, full, overrun, rx_on}, 32'h8);
    check("R1 rd_data", rd_data, 0);

    // R2 pushes while off are dropped
    mode = 2'b00;
    push(20'h000AA, 0); push(20'h000BB, 0);
    check("R2 off push ignored", 32'(level), 0);
    cmd_en();
    check("R2 enable", 32'(rx_on), 1);
    for (int i = 0; i < 5; i++) push(20'(8'h11 * (i + 1)), 0);
    check("R5 level after five bytes", 32'(level), 5);
    rd(2'b10, "R5 four bytes");
    rd(2'b01, "R9 short read two asked one left");
    cyc();
    check("R9 level drained", 32'(level), 0);
    rd(2'b10, "R9 empty read zero");
    cyc();
    check("R9 empty read keeps level", 32'(level), 0);

    // R3 / R4 byte capacity and overrun
    mode = 2'b01;
    for (int i = 0; i < 32; i++) push(20'(i + 8'h40), 0);
    check("R3 level 32", 32'(level), 32);
    check("R3 full", 32'(full), 1);
    push(20'h000FF, 0);
    check("R4 overrun set", 32'(overrun), 1);
    check("R4 level kept", 32'(level), 32);
    rd(2'b00, "R12 byte one");
    rd(2'b01, "R5 two bytes");
    cyc();
    check("R4 overrun sticky", 32'(overrun), 1);

    // R11 receiver reset with same-cycle push and read
    cmd_rst();
    check("R11 level", 32'(level), 0);
    check("R11 flags", {29'h0, overrun, rx_on, |rd_data}, 0);
    push(20'h00077, 0);
    check("R11 stays off", 32'(level), 0);

    // R6 halfwords
    cmd_en();
    mode = 2'b10;
    push(20'h0A1B2, 0); push(20'h0C3D4, 0); push(20'h0E5F6, 0);
    rd(2'b10, "R6 count four gives two halfwords");
    rd(2'b00, "R6 one halfword");
    cyc();
    check("R6 level", 32'(level), 0);

    // R10 read while disabled
    push(20'h01234, 0); push(20'h05678, 0);
    cmd_dis();
    push(20'h09999, 0);
    check("R10 level while off", 32'(level), 2);
    rd(2'b01, "R10 read while disabled");
    cyc();

    // R2 priority
    rx_enable = 1; rx_disable = 1; cyc(); rx_enable = 0; rx_disable = 0;
    check("R2 disable wins", 32'(rx_on), 0);

    // R7 / R8 time slots
    cmd_rst(); cmd_en();
    mode = 2'b11;
    push(20'h5ABCD, 1); push(20'h12345, 0); push(20'hFEDCB, 0);
    rd(2'b10, "R8 first slot");
    cyc();
    check("R7 one slot per read", 32'(level), 2);
    rd(2'b01, "R7 plain slot");
    rd(2'b00, "R7 plain slot two");

    // R4 same-cycle read and push at full
    cmd_rst(); cmd_en();
    mode = 2'b10;
    for (int i = 0; i < 16; i++) push(20'(16'h1000 + i), 0);
    check("R3 half full at 16", 32'(full), 1);
    build(2'b00, w);
    exp_q.push_back(w); tag_q.push_back("R4 head on same-cycle read");
    mq.push_back({1'b0, 20'h0BEEF});
    rd_req = 1; rd_cnt = 2'b00; push_vld = 1; push_data = 20'h0BEEF;
    cyc(); rd_req = 0; push_vld = 0;
    check("R4 level after swap", 32'(level), 16);
    check("R4 no overrun after swap", 32'(overrun), 0);
    push(20'h0DEAD, 0);
    check("R4 lone push overruns", 32'(overrun), 1);
    for (int i = 0; i < 8; i++) rd(2'b01, "R12 drain order");
    cyc(); cyc();
    check("R12 drained", 32'(level), 0);
    check("R12 scoreboard empty", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule